// File: doc/BRIEF.md
# Program Sequencer with Hardware Return Stack and Banked Flags

This block sequences program flow for a small 8-bit controller whose program and data spaces are separate. It holds a 12-bit program counter that addresses 4096 program locations. It moves the counter on decoded strobes: step to the next location, absolute jump, absolute call, return, conditional short branch, and return from interrupt. Return addresses go onto a dedicated return stack of a few entries that is built into the block and never appears in data memory.

Carry and zero are kept in three separate copies, one for each processor mode: normal, interrupt and non-maskable interrupt. The copy of the current mode drives the flag outputs and takes flag writes. Taking an interrupt pushes the program counter and loads a fixed vector. Returning from an interrupt restores the earlier mode, and with it that mode's flag copy. Each stack entry stores the mode together with the return address. A sticky status bit reports any push onto a full stack and any pop from an empty one.

Top module: `prog_sequencer`

## Requirements
- R1: After reset the program counter is 0, the mode is normal (code 0), both active flags read 0 and the stack status bit is 0.
- R2: A step strobe alone advances the program counter by one, and 12'hFFF wraps to 12'h000. With no strobe at all the counter holds its value.
- R3: A jump loads the counter with {tgt_hi_i, tgt_lo_i}, where the 4-bit field forms bits 11:8, and pushes nothing onto the return stack.
- R4: A call pushes the address after the current one and loads {tgt_hi_i, tgt_lo_i}. A return pops that address into the counter and leaves the mode unchanged. Nested calls return in last-in, first-out order.
- R5: A branch tests the flag picked by br_cond_i[1] (0 = zero, 1 = carry) against the level in br_cond_i[0]. When they match, the counter becomes itself plus the sign-extended 5-bit br_off_i, modulo 4096. Otherwise it advances by one.
- R6: A flag write changes only the copy that belongs to the current mode. The other two copies keep their values, and the outputs show the new value one cycle after the write.
- R7: An ordinary interrupt request is taken only in normal mode. It pushes the current counter, loads IRQ_VEC and enters interrupt mode (code 1).
- R8: A non-maskable request is taken in normal or interrupt mode. It pushes the current counter, loads NMI_VEC and enters non-maskable mode (code 2). It wins over an ordinary request in the same cycle.
- R9: An ordinary request in interrupt or non-maskable mode is ignored. Mode and counter stay as they are.
- R10: Return from interrupt pops the counter and restores the mode held in the popped entry, so the flag outputs show that mode's copy again.
- R11: A push onto a full stack overwrites the oldest entry and sets the sticky status bit. The remaining DEPTH entries still return in last-in, first-out order.
- R12: A pop from an empty stack leaves the stack pointer in place, returns the entry popped most recently, and sets the status bit.
- R13: When several strobes arrive together, one acts, in this priority: non-maskable entry, interrupt entry, return from interrupt, return, call, jump, branch, step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| adv_i | input | 1 | Step to next location |
| jump_i | input | 1 | Absolute jump |
| call_i | input | 1 | Absolute call |
| tgt_hi_i | input | 4 | Target bits 11:8 |
| tgt_lo_i | input | 8 | Target bits 7:0 |
| br_i | input | 1 | Conditional short branch |
| br_cond_i | input | 2 | [1] flag select, [0] level that takes the branch |
| br_off_i | input | 5 | Signed branch offset |
| ret_i | input | 1 | Return from subroutine |
| reti_i | input | 1 | Return from interrupt |
| flag_we_i | input | 1 | Write flags of current mode |
| c_i | input | 1 | Carry value to write |
| z_i | input | 1 | Zero value to write |
| irq_i | input | 1 | Ordinary interrupt request |
| nmi_i | input | 1 | Non-maskable interrupt request |
| pc_o | output | 12 | Fetch address |
| c_o | output | 1 | Active carry |
| z_o | output | 1 | Active zero |
| mode_o | output | 2 | Current mode (0 normal, 1 interrupt, 2 non-maskable) |
| ovf_o | output | 1 | Sticky stack overflow/underflow status |

## Verification
The bench builds the block with DEPTH=4, IRQ_VEC=12'h010 and NMI_VEC=12'h020. The shallow stack lets five nested calls reach the overwrite case, and popping past it reaches the empty case, all in a few dozen cycles. The branch sweep covers every offset, condition code and flag pair from three base addresses, two of them at the ends of program space, so both wrap directions are checked. The distinct vectors make every interrupt entry visible on the fetch address.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
    localparam int PC_W  = 12;
    localparam int HI_W  = 4;
    localparam int LO_W  = 8;
    localparam int OFF_W = 5;
    localparam int NBANK = 3;

    typedef enum logic [1:0] {
        MODE_NORM = 2'd0,
        MODE_IRQ  = 2'd1,
        MODE_NMI  = 2'd2
    } mode_e;

    typedef struct packed {
        mode_e             mode;
        logic [PC_W-1:0]   pc;
    } ret_ent_t;
endpackage

// File: rtl/ret_stack.sv
module ret_stack
    import prog_seq_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push_i,
    input  logic     pop_i,
    input  ret_ent_t push_ent_i,
    output ret_ent_t pop_ent_o,
    output logic     ovf_o
);
    localparam int              PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0]   LAST  = PW'(DEPTH - 1);
    localparam logic [PW-1:0]   P_ONE = PW'(1);
    localparam logic [PW:0]     FULL  = (PW+1)'(DEPTH);
    localparam logic [PW:0]     C_ONE = (PW+1)'(1);

    typedef struct packed {
        ret_ent_t [DEPTH-1:0] mem;
        logic     [PW-1:0]    wp;
        logic     [PW:0]      cnt;
        logic                 ovf;
    } stk_t;

    stk_t q, d;
    logic [PW-1:0] wp_inc, wp_dec;

    always_comb begin
        wp_inc = (q.wp == LAST) ? '0 : q.wp + P_ONE;
        wp_dec = (q.wp == '0) ? LAST : q.wp - P_ONE;
        // empty: the slot under wp holds the entry popped last
        pop_ent_o = (q.cnt == '0) ? q.mem[q.wp] : q.mem[wp_dec];
        d = q;
        if (push_i) begin
            d.mem[q.wp] = push_ent_i;
            d.wp        = wp_inc;
            if (q.cnt == FULL) d.ovf = 1'b1;
            else               d.cnt = q.cnt + C_ONE;
        end else if (pop_i) begin
            if (q.cnt == '0) begin
                d.ovf = 1'b1;
            end else begin
                d.wp  = wp_dec;
                d.cnt = q.cnt - C_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ovf_o = q.ovf;
endmodule

// File: rtl/flag_banks.sv
module flag_banks
    import prog_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we_i,
    input  mode_e sel_i,
    input  logic  c_i,
    input  logic  z_i,
    output logic  c_o,
    output logic  z_o
);
    typedef struct packed {
        logic [NBANK-1:0] c;
        logic [NBANK-1:0] z;
    } fl_t;

    fl_t q, d;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit    = we_i && (sel_i == mode_e'(b));
        assign d.c[b] = hit ? c_i : q.c[b];
        assign d.z[b] = hit ? z_i : q.z[b];
    end

    always_comb begin
        case (sel_i)
            MODE_IRQ: begin c_o = q.c[1]; z_o = q.z[1]; end
            MODE_NMI: begin c_o = q.c[2]; z_o = q.z[2]; end
            default:  begin c_o = q.c[0]; z_o = q.z[0]; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
    import prog_seq_pkg::*;
#(
    parameter int              DEPTH   = 6,
    parameter logic [PC_W-1:0] IRQ_VEC = 12'h010,
    parameter logic [PC_W-1:0] NMI_VEC = 12'h020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              jump_i,
    input  logic              call_i,
    input  logic [HI_W-1:0]   tgt_hi_i,
    input  logic [LO_W-1:0]   tgt_lo_i,
    input  logic              br_i,
    input  logic [1:0]        br_cond_i,
    input  logic [OFF_W-1:0]  br_off_i,
    input  logic              ret_i,
    input  logic              reti_i,
    input  logic              flag_we_i,
    input  logic              c_i,
    input  logic              z_i,
    input  logic              irq_i,
    input  logic              nmi_i,
    output logic [PC_W-1:0]   pc_o,
    output logic              c_o,
    output logic              z_o,
    output logic [1:0]        mode_o,
    output logic              ovf_o
);
    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        mode_e           mode;
    } seq_t;

    seq_t            q, d;
    logic            take_nmi, take_irq, br_flag, br_taken;
    logic            push, pop, c_cur, z_cur;
    logic [PC_W-1:0] pc_inc, off_ext;
    ret_ent_t        push_ent, pop_ent;

    always_comb begin
        take_nmi = nmi_i && (q.mode != MODE_NMI);
        take_irq = irq_i && (q.mode == MODE_NORM) && !take_nmi;
        br_flag  = br_cond_i[1] ? c_cur : z_cur;
        br_taken = (br_flag == br_cond_i[0]);
        off_ext  = {{(PC_W-OFF_W){br_off_i[OFF_W-1]}}, br_off_i};
        pc_inc   = q.pc + PC_ONE;
        push          = 1'b0;
        pop           = 1'b0;
        push_ent.mode = q.mode;
        push_ent.pc   = pc_inc;
        d = q;
        if (take_nmi) begin
            push        = 1'b1;
            push_ent.pc = q.pc;
            d.pc        = NMI_VEC;
            d.mode      = MODE_NMI;
        end else if (take_irq) begin
            push        = 1'b1;
            push_ent.pc = q.pc;
            d.pc        = IRQ_VEC;
            d.mode      = MODE_IRQ;
        end else if (reti_i) begin
            pop    = 1'b1;
            d.pc   = pop_ent.pc;
            d.mode = pop_ent.mode;
        end else if (ret_i) begin
            pop  = 1'b1;
            d.pc = pop_ent.pc;
        end else if (call_i) begin
            push = 1'b1;
            d.pc = {tgt_hi_i, tgt_lo_i};
        end else if (jump_i) begin
            d.pc = {tgt_hi_i, tgt_lo_i};
        end else if (br_i) begin
            d.pc = br_taken ? (q.pc + off_ext) : pc_inc;
        end else if (adv_i) begin
            d.pc = pc_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{pc: '0, mode: MODE_NORM};
        else        q <= d;
    end

    ret_stack #(.DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .pop_i      (pop),
        .push_ent_i (push_ent),
        .pop_ent_o  (pop_ent),
        .ovf_o      (ovf_o)
    );

    flag_banks u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (flag_we_i),
        .sel_i (q.mode),
        .c_i   (c_i),
        .z_i   (z_i),
        .c_o   (c_cur),
        .z_o   (z_cur)
    );

    assign pc_o   = q.pc;
    assign mode_o = q.mode;
    assign c_o    = c_cur;
    assign z_o    = z_cur;
endmodule

// File: rtl/prog_seq_checker.sv
module prog_seq_checker #(
    parameter logic [11:0] IRQ_VEC = 12'h010,
    parameter logic [11:0] NMI_VEC = 12'h020
) (
    input logic        clk,
    input logic        rst_n,
    input logic        adv_i,
    input logic        jump_i,
    input logic        call_i,
    input logic [3:0]  tgt_hi_i,
    input logic [7:0]  tgt_lo_i,
    input logic        br_i,
    input logic        ret_i,
    input logic        reti_i,
    input logic        flag_we_i,
    input logic        irq_i,
    input logic        nmi_i,
    input logic [11:0] pc_o,
    input logic        c_o,
    input logic        z_o,
    input logic [1:0]  mode_o,
    input logic        ovf_o
);
    logic quiet;
    assign quiet = !jump_i && !call_i && !br_i && !ret_i && !reti_i && !irq_i && !nmi_i;

    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && adv_i) |=> (pc_o == 12'($past(pc_o) + 12'd1)));           // R2
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !adv_i) |=> $stable(pc_o));                                // R2
    AST_JUMP_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_i && !call_i && !ret_i && !reti_i && !irq_i && !nmi_i)
        |=> (pc_o == $past({tgt_hi_i, tgt_lo_i})));                          // R3
    AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && !nmi_i && mode_o == 2'd0) |=> (pc_o == IRQ_VEC && mode_o == 2'd1)); // R7
    AST_NMI_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_i && mode_o != 2'd2) |=> (pc_o == NMI_VEC && mode_o == 2'd2));  // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && !nmi_i && !reti_i && mode_o != 2'd0) |=> $stable(mode_o)); // R9
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we_i && !irq_i && !nmi_i && !reti_i) |=> $stable({c_o, z_o})); // R6
    AST_NO_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);                                                    // R11
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3);                                                     // R10
endmodule

bind prog_sequencer prog_seq_checker #(.IRQ_VEC(IRQ_VEC), .NMI_VEC(NMI_VEC)) u_chk (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .jump_i(jump_i), .call_i(call_i),
    .tgt_hi_i(tgt_hi_i), .tgt_lo_i(tgt_lo_i), .br_i(br_i), .ret_i(ret_i),
    .reti_i(reti_i), .flag_we_i(flag_we_i), .irq_i(irq_i), .nmi_i(nmi_i),
    .pc_o(pc_o), .c_o(c_o), .z_o(z_o), .mode_o(mode_o), .ovf_o(ovf_o)
);

// File: tb/sim_prog_sequencer.sv
module sim_prog_sequencer;
    localparam logic [11:0] IRQV = 12'h010;
    localparam logic [11:0] NMIV = 12'h020;

    logic clk = 1'b0;
    logic rst_n;
    logic adv_i, jump_i, call_i, br_i, ret_i, reti_i, flag_we_i, c_i, z_i, irq_i, nmi_i;
    logic [3:0]  tgt_hi_i;
    logic [7:0]  tgt_lo_i;
    logic [1:0]  br_cond_i;
    logic [4:0]  br_off_i;
    logic [11:0] pc_o;
    logic        c_o, z_o, ovf_o;
    logic [1:0]  mode_o;
    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    prog_sequencer #(.DEPTH(4), .IRQ_VEC(IRQV), .NMI_VEC(NMIV)) u0 (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .jump_i(jump_i), .call_i(call_i),
        .tgt_hi_i(tgt_hi_i), .tgt_lo_i(tgt_lo_i), .br_i(br_i), .br_cond_i(br_cond_i),
        .br_off_i(br_off_i), .ret_i(ret_i), .reti_i(reti_i), .flag_we_i(flag_we_i),
        .c_i(c_i), .z_i(z_i), .irq_i(irq_i), .nmi_i(nmi_i), .pc_o(pc_o), .c_o(c_o),
        .z_o(z_o), .mode_o(mode_o), .ovf_o(ovf_o)
    );

    task automatic clr();
        adv_i = 0; jump_i = 0; call_i = 0; br_i = 0; ret_i = 0; reti_i = 0;
        flag_we_i = 0; c_i = 0; z_i = 0; irq_i = 0; nmi_i = 0;
        tgt_hi_i = '0; tgt_lo_i = '0; br_cond_i = '0; br_off_i = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        clr();
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        clr();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic set_tgt(input logic [11:0] t);
        tgt_hi_i = t[11:8];
        tgt_lo_i = t[7:0];
    endtask

    task automatic jump(input logic [11:0] t);
        jump_i = 1; set_tgt(t); tick();
    endtask

    task automatic call(input logic [11:0] t);
        call_i = 1; set_tgt(t); tick();
    endtask

    task automatic ret();
        ret_i = 1; tick();
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [11:0] bases [3];
        bases[0] = 12'h001; bases[1] = 12'h800; bases[2] = 12'hFFE;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 pc", {4'h0, pc_o}, 16'h0000);
        chk("R1 mode/flags/ovf", {11'h0, mode_o, c_o, z_o, ovf_o}, 16'h0000);

        // R2 step, wrap and hold
        adv_i = 1; tick();
        chk("R2 step", {4'h0, pc_o}, 16'h0001);
        jump(12'hFFF);
        adv_i = 1; tick();
        chk("R2 wrap", {4'h0, pc_o}, 16'h0000);
        tick();
        chk("R2 hold", {4'h0, pc_o}, 16'h0000);

        // R3 jump target sweep over every high field
        for (int h = 0; h < 16; h++) begin
            for (int k = 0; k < 3; k++) begin
                logic [7:0] lo;
                lo = (k == 0) ? 8'h00 : (k == 1) ? 8'h5A : 8'hFF;
                jump({4'(h), lo});
                chk("R3 jump", {4'h0, pc_o}, {4'h0, 4'(h), lo});
            end
        end

        // R5 branch sweep; R6 flag write in normal mode
        for (int b = 0; b < 3; b++) begin
            for (int cnd = 0; cnd < 4; cnd++) begin
                for (int fl = 0; fl < 4; fl++) begin
                    for (int off = 0; off < 32; off++) begin
                        logic [1:0]  cc;
                        logic [1:0]  ff;
                        logic [4:0]  o5;
                        logic [11:0] exp;
                        logic        sel;
                        cc = 2'(cnd); ff = 2'(fl); o5 = 5'(off);
                        jump_i = 1; set_tgt(bases[b]);
                        flag_we_i = 1; c_i = ff[1]; z_i = ff[0];
                        tick();
                        if (off == 0) chk("R6 flags", {14'h0, c_o, z_o}, {14'h0, ff});
                        br_i = 1; br_cond_i = cc; br_off_i = o5;
                        tick();
                        sel = cc[1] ? ff[1] : ff[0];
                        exp = (sel == cc[0]) ? 12'(bases[b] + {{7{o5[4]}}, o5})
                                             : 12'(bases[b] + 12'd1);
                        chk("R5 branch", {4'h0, pc_o}, {4'h0, exp});
                    end
                end
            end
        end

        // R4 nested calls within depth, then R12 empty pop
        do_reset();
        jump(12'h100);
        for (int i = 0; i < 4; i++) call(12'(12'h200 + i * 16));
        chk("R4 no ovf at depth", {15'h0, ovf_o}, 16'h0000);
        for (int i = 3; i >= 0; i--) begin
            ret();
            chk("R4 ret order", {4'h0, pc_o}, (i == 0) ? 16'h0101 : 16'(16'h0201 + (i - 1) * 16));
        end
        chk("R4 mode kept", {14'h0, mode_o}, 16'h0000);
        chk("R4 no ovf", {15'h0, ovf_o}, 16'h0000);
        ret();
        chk("R12 empty pop value", {4'h0, pc_o}, 16'h0101);
        chk("R12 empty pop status", {15'h0, ovf_o}, 16'h0001);

        // R11 overflow overwrites oldest
        do_reset();
        jump(12'h100);
        for (int i = 0; i < 5; i++) begin
            call(12'(12'h200 + i * 16));
            if (i == 3) chk("R11 full no ovf", {15'h0, ovf_o}, 16'h0000);
        end
        chk("R11 ovf set", {15'h0, ovf_o}, 16'h0001);
        for (int i = 4; i >= 1; i--) begin
            ret();
            chk("R11 survivors", {4'h0, pc_o}, 16'(16'h0201 + (i - 1) * 16));
        end
        ret();
        chk("R12 after overflow", {4'h0, pc_o}, 16'h0201);

        // R3 jump does not push
        do_reset();
        call(12'h300);
        jump(12'h400);
        ret();
        chk("R3 no push", {4'h0, pc_o}, 16'h0001);

        // R7..R10 interrupts and banked flags
        do_reset();
        jump_i = 1; set_tgt(12'h345); flag_we_i = 1; c_i = 1; z_i = 0; tick();
        irq_i = 1; tick();
        chk("R7 irq pc", {4'h0, pc_o}, {4'h0, IRQV});
        chk("R7 irq mode", {14'h0, mode_o}, 16'h0001);
        chk("R6 irq bank fresh", {14'h0, c_o, z_o}, 16'h0000);
        adv_i = 1; tick();
        flag_we_i = 1; c_i = 0; z_i = 1; tick();
        chk("R6 irq bank write", {14'h0, c_o, z_o}, 16'h0001);
        irq_i = 1; tick();
        chk("R9 irq in irq", {2'h0, mode_o, pc_o}, {4'h1, 12'(IRQV + 12'd1)});
        nmi_i = 1; tick();
        chk("R8 nmi nests", {2'h0, mode_o, pc_o}, {4'h2, NMIV});
        chk("R6 nmi bank fresh", {14'h0, c_o, z_o}, 16'h0000);
        flag_we_i = 1; c_i = 1; z_i = 1; tick();
        chk("R6 nmi bank write", {14'h0, c_o, z_o}, 16'h0003);
        irq_i = 1; tick();
        chk("R9 irq in nmi", {2'h0, mode_o, pc_o}, {4'h2, NMIV});
        nmi_i = 1; tick();
        chk("R8 nmi not reentered", {2'h0, mode_o, pc_o}, {4'h2, NMIV});
        reti_i = 1; tick();
        chk("R10 back to irq", {2'h0, mode_o, pc_o}, {4'h1, 12'(IRQV + 12'd1)});
        chk("R10 irq flags", {14'h0, c_o, z_o}, 16'h0001);
        reti_i = 1; tick();
        chk("R10 back to normal", {2'h0, mode_o, pc_o}, 16'h0345);
        chk("R10 normal flags", {14'h0, c_o, z_o}, 16'h0002);

        // R13 priority
        irq_i = 1; nmi_i = 1; tick();
        chk("R13 nmi over irq", {2'h0, mode_o, pc_o}, {4'h2, NMIV});
        reti_i = 1; ret_i = 1; tick();
        chk("R13 reti over ret", {2'h0, mode_o, pc_o}, 16'h0345);
        call_i = 1; jump_i = 1; adv_i = 1; set_tgt(12'h123); tick();
        chk("R13 call over jump", {4'h0, pc_o}, 16'h0123);
        ret();
        chk("R13 call pushed", {4'h0, pc_o}, 16'h0346);
        irq_i = 1; call_i = 1; set_tgt(12'h777); tick();
        chk("R13 irq over call", {2'h0, mode_o, pc_o}, {4'h1, IRQV});
        reti_i = 1; tick();
        chk("R13 irq pushed pc", {2'h0, mode_o, pc_o}, 16'h0346);
        br_i = 1; adv_i = 1; br_cond_i = 2'b11; br_off_i = 5'd4; tick();
        chk("R13 branch over step", {4'h0, pc_o}, 16'h034A);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule